// File: doc/BRIEF.md
# Ethernet Controller Reset Sequencer

This block orders the reset and power-saving events of a small Ethernet MAC/PHY controller. An active-low board reset pin is first filtered. Only a low level that persists for a minimum time counts as a reset request. A qualified request resets every MAC and PHY register. When the pin goes high again, the block latches the strap inputs, waits a short settling time, and then asks the configuration-memory loader to start. The controller reports ready only when the loader signals completion.

Software can also request a shorter reset through a control-register write. This reset clears only part of the register state and ends on its own after a fixed time. Two independent power-down bits are merged into one PHY power-down signal, which also gates the transmit and receive enable. All time constants are given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `eth_rst_seq`

## Requirements
- R1: A low level on `hw_rst_pin_n` that lasts fewer than HW_MIN_US microseconds (two synchroniser cycles are added) has no effect: `mac_rst` stays 0 and `ready` keeps its value.
- R2: A low level that lasts at least HW_MIN_US drives `mac_rst` and `phy_rst` to 1, drives `ready` to 0 and clears both power-down bits. All of these stay so while the pin remains low.
- R3: When the pin is seen high after a qualified reset, `strap_latch` pulses for exactly one cycle. `mac_rst` and `phy_rst` drop on the following cycle.
- R4: `ld_start` pulses for one cycle exactly WAKE_US microseconds after the `strap_latch` cycle. `ready` stays 0 from the reset until the loader finishes.
- R5: `ready` rises on the cycle after `ld_done` is seen while a load is pending. `ld_done` has no effect at any other time.
- R6: A write to address 0 (network control) with data bit 0 set, while `ready` is 1, raises `soft_rst` and `rst_bit` for exactly SW_US microseconds. `ready` is 0 during that time and then returns to 1. `mac_rst` stays 0. A write to address 0 with bit 0 clear does nothing.
- R7: A software reset clears the general-purpose power-down bit. The PHY-control power-down bit keeps its value.
- R8: `phy_pd` is the OR of the general-purpose power-down bit (address 1, data bit 0) and the PHY-control power-down bit (address 2, data bit 11). Each bit takes its new value on the cycle after the write. `txrx_en` equals `ready` AND NOT `phy_pd`.
- R9: Register writes are ignored unless `ready` is 1.
- R10: A qualified hardware reset during a software reset or a pending load aborts that operation and restarts the full hardware sequence.
- R11: After `sys_rst_n` is released, `mac_rst` and `phy_rst` are 1 and `ready` is 0. The block stays in that state until it sees a first qualified pin reset and completes the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, CLK_HZ |
| sys_rst_n | input | 1 | Asynchronous active-low reset of the sequencer itself |
| hw_rst_pin_n | input | 1 | Asynchronous active-low board reset pin, filtered |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 network control, 1 general purpose, 2 PHY control |
| wr_data | input | DATA_W | Write data |
| ld_done | input | 1 | Configuration loader finished |
| mac_rst | output | 1 | Full MAC register reset |
| phy_rst | output | 1 | Full PHY register reset |
| soft_rst | output | 1 | Partial register reset for software reset |
| strap_latch | output | 1 | One-cycle strap capture strobe |
| ld_start | output | 1 | One-cycle loader start request |
| ready | output | 1 | Controller operational |
| rst_bit | output | 1 | Read value of the software reset bit |
| phy_pd | output | 1 | PHY power-down |
| txrx_en | output | 1 | Transmit/receive path enable |

## Verification
The sequencer's phase is visible at the ports in every cycle. If the internal phase is wrong, one of `mac_rst`, `soft_rst` or `ready` shows the wrong level within one cycle. A phase timer that runs short or long moves the `ld_start` pulse or the fall of `rst_bit`, and the bench measures both to the cycle against the microsecond parameters. A filter counter that qualifies too early makes a short glitch produce a `strap_latch` pulse the scoreboard does not expect. A power-down bit with the wrong value shows on `phy_pd` and `txrx_en` one cycle after the write or reset that set it.

// File: rtl/eth_rst_pkg.sv
package eth_rst_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP = 3'd0,
    ST_HOLD  = 3'd1,
    ST_WAKE  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_RUN   = 3'd4,
    ST_SWRST = 3'd5
  } seq_state_t;

  localparam logic [1:0] RA_NETCTL = 2'd0;
  localparam logic [1:0] RA_GPREG  = 2'd1;
  localparam logic [1:0] RA_PHYCTL = 2'd2;

  localparam int NETCTL_RST_BIT = 0;
  localparam int GPREG_PD_BIT   = 0;
  localparam int PHYCTL_PD_BIT  = 11;

  function automatic int us_to_cyc(input int clk_hz, input int us);
    int c;
    c = (clk_hz / 1_000_000) * us;
    return (c < 2) ? 2 : c;
  endfunction

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int MIN_CYC     = 500_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n,
  output logic pin_hi_o,
  output logic qual_o
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_CYC);
  localparam logic [CW-1:0] CNT_HIT = CW'(MIN_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CW-1:0]          low_q, low_d;
  logic                   low_en;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_n};
  end

  assign pin_hi_o = sync_q[SYNC_STAGES-1];

  always_comb begin
    low_en = 1'b0;
    low_d  = low_q;
    if (pin_hi_o) begin
      low_en = (low_q != '0);
      low_d  = '0;
    end else if (low_q != CNT_MAX) begin
      low_en = 1'b1;
      low_d  = low_q + 1'b1;
    end
  end

  assign qual_o = !pin_hi_o && (low_q == CNT_HIT);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     low_q <= '0;
    else if (low_en) low_q <= low_d;
  end

  AST_QUAL_AFTER_LOW: assert property (@(posedge clk) disable iff (!arst_n)
    qual_o |-> $past(!pin_hi_o)) else $error("qualified without a low level"); // R1

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import eth_rst_pkg::*;
#(
  parameter int WAKE_CYC = 125,
  parameter int SW_CYC   = 250
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_hi_i,
  input  logic qual_i,
  input  logic ld_done_i,
  input  logic soft_req_i,
  output logic hw_rst_o,
  output logic soft_rst_o,
  output logic strap_o,
  output logic ld_start_o,
  output logic ready_o
);
  localparam int TMAX = (WAKE_CYC > SW_CYC) ? WAKE_CYC : SW_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] WAKE_LAST = TW'(WAKE_CYC - 1);
  localparam logic [TW-1:0] SW_LAST   = TW'(SW_CYC - 1);
  localparam logic [TW-1:0] T_SAT     = TW'(TMAX);

  seq_state_t    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_PWRUP: st_d = ST_PWRUP;
      ST_HOLD:  if (pin_hi_i)            st_d = ST_WAKE;
      ST_WAKE:  if (tmr_q == WAKE_LAST)  st_d = ST_LOAD;
      ST_LOAD:  if (ld_done_i)           st_d = ST_RUN;
      ST_RUN:   if (soft_req_i)          st_d = ST_SWRST;
      ST_SWRST: if (tmr_q == SW_LAST)    st_d = ST_RUN;
      default:                           st_d = ST_PWRUP;
    endcase
    if (qual_i) st_d = ST_HOLD;
  end

  always_comb begin
    tmr_en = 1'b0;
    tmr_d  = tmr_q;
    if (st_d != st_q) begin
      tmr_en = 1'b1;
      tmr_d  = '0;
    end else if (tmr_q != T_SAT) begin
      tmr_en = 1'b1;
      tmr_d  = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) st_q <= ST_PWRUP;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  assign hw_rst_o   = (st_q == ST_PWRUP) || (st_q == ST_HOLD);
  assign soft_rst_o = (st_q == ST_SWRST);
  assign strap_o    = (st_q == ST_HOLD) && pin_hi_i;
  assign ld_start_o = (st_q == ST_WAKE) && (tmr_q == WAKE_LAST);
  assign ready_o    = (st_q == ST_RUN);

  AST_HW_ON_QUAL: assert property (@(posedge clk) disable iff (!arst_n)
    qual_i |=> hw_rst_o) else $error("qualified pin reset not applied"); // R10
  AST_STRAP_THEN_WAKE: assert property (@(posedge clk) disable iff (!arst_n)
    strap_o |=> (!ready_o && !soft_rst_o)) else $error("strap not followed by wake"); // R3
  AST_LDSTART_ONE: assert property (@(posedge clk) disable iff (!arst_n)
    ld_start_o |=> !ld_start_o) else $error("loader start wider than a cycle"); // R4
  AST_READY_NEEDS_DONE: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(ready_o) |-> ($past(ld_done_i) || $past(soft_rst_o))) else $error("ready without cause"); // R5
  AST_SOFT_FROM_RUN: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(soft_rst_o) |-> ($past(ready_o) && $past(soft_req_i))) else $error("soft reset outside run"); // R6

endmodule

// File: rtl/pd_regs.sv
module pd_regs
  import eth_rst_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       hw_clr_i,
  input  logic       soft_clr_i,
  input  logic       wr_ok_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic       gp_bit_i,
  input  logic       ph_bit_i,
  output logic       phy_pd_o
);
  logic gp_q, gp_d, ph_q, ph_d;
  logic wr_gp, wr_ph;

  assign wr_gp = wr_ok_i && wr_en_i && (wr_addr_i == RA_GPREG);
  assign wr_ph = wr_ok_i && wr_en_i && (wr_addr_i == RA_PHYCTL);

  always_comb begin
    gp_d = gp_q;
    if (hw_clr_i || soft_clr_i) gp_d = 1'b0;
    else if (wr_gp)             gp_d = gp_bit_i;
  end

  always_comb begin
    ph_d = ph_q;
    if (hw_clr_i)   ph_d = 1'b0;
    else if (wr_ph) ph_d = ph_bit_i;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      gp_q <= 1'b0;
      ph_q <= 1'b0;
    end else begin
      gp_q <= gp_d;
      ph_q <= ph_d;
    end
  end

  assign phy_pd_o = gp_q | ph_q;

  AST_PD_CLR_HW: assert property (@(posedge clk) disable iff (!arst_n)
    hw_clr_i |=> !phy_pd_o) else $error("power-down survived full reset"); // R2
  AST_PH_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!arst_n)
    (!wr_ok_i && !hw_clr_i) |=> $stable(ph_q)) else $error("phy bit changed while writes blocked"); // R9

endmodule

// File: rtl/eth_rst_seq.sv
module eth_rst_seq
  import eth_rst_pkg::*;
#(
  parameter int CLK_HZ    = 25_000_000,
  parameter int HW_MIN_US = 20_000,
  parameter int WAKE_US   = 5,
  parameter int SW_US     = 10,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              hw_rst_pin_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ld_done,
  output logic              mac_rst,
  output logic              phy_rst,
  output logic              soft_rst,
  output logic              strap_latch,
  output logic              ld_start,
  output logic              ready,
  output logic              rst_bit,
  output logic              phy_pd,
  output logic              txrx_en
);
  localparam int HW_MIN_CYC = us_to_cyc(CLK_HZ, HW_MIN_US);
  localparam int WAKE_CYC   = us_to_cyc(CLK_HZ, WAKE_US);
  localparam int SW_CYC     = us_to_cyc(CLK_HZ, SW_US);

  logic pin_hi, qual, hw_rst, soft_req;
  logic unused_wdata;

  assign unused_wdata = ^wr_data;

  rst_pin_filter #(.MIN_CYC(HW_MIN_CYC), .SYNC_STAGES(2)) u_filt (
    .clk      (clk),
    .arst_n   (sys_rst_n),
    .pin_n    (hw_rst_pin_n),
    .pin_hi_o (pin_hi),
    .qual_o   (qual)
  );

  assign soft_req = ready && wr_en && (wr_addr == RA_NETCTL) && wr_data[NETCTL_RST_BIT];

  rst_seq_fsm #(.WAKE_CYC(WAKE_CYC), .SW_CYC(SW_CYC)) u_fsm (
    .clk        (clk),
    .arst_n     (sys_rst_n),
    .pin_hi_i   (pin_hi),
    .qual_i     (qual),
    .ld_done_i  (ld_done),
    .soft_req_i (soft_req),
    .hw_rst_o   (hw_rst),
    .soft_rst_o (soft_rst),
    .strap_o    (strap_latch),
    .ld_start_o (ld_start),
    .ready_o    (ready)
  );

  pd_regs u_pd (
    .clk        (clk),
    .arst_n     (sys_rst_n),
    .hw_clr_i   (hw_rst),
    .soft_clr_i (soft_rst),
    .wr_ok_i    (ready),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .gp_bit_i   (wr_data[GPREG_PD_BIT]),
    .ph_bit_i   (wr_data[PHYCTL_PD_BIT]),
    .phy_pd_o   (phy_pd)
  );

  assign mac_rst = hw_rst;
  assign phy_rst = hw_rst;
  assign rst_bit = soft_rst;
  assign txrx_en = ready && !phy_pd;

  initial begin
    AST_DATA_WIDE: assert (DATA_W > PHYCTL_PD_BIT) else $error("data too narrow"); // R8
  end

endmodule

// File: tb/tb_eth_rst_seq.sv
module tb_eth_rst_seq;
  localparam int WAKE_CYC = 5;
  localparam int SW_CYC   = 20;
  localparam int EV_STRAP = 1, EV_LD = 2, EV_READY = 3, EV_SOFT = 4;

  logic clk = 1'b0;
  logic sys_rst_n, pin_n, wr_en, ld_done;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic mac_rst, phy_rst, soft_rst, strap_latch, ld_start, ready, rst_bit, phy_pd, txrx_en;

  int nchk = 0, nfail = 0, cyc = 0, strap_cyc = 0, busy_len = 0;
  int exp_q[$];
  logic prev_ready = 1'b0, prev_soft = 1'b0;

  always #5 clk = ~clk;

  eth_rst_seq #(.CLK_HZ(1_000_000), .HW_MIN_US(8), .WAKE_US(WAKE_CYC), .SW_US(SW_CYC), .DATA_W(16)) dut (
    .clk(clk), .sys_rst_n(sys_rst_n), .hw_rst_pin_n(pin_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ld_done(ld_done), .mac_rst(mac_rst), .phy_rst(phy_rst), .soft_rst(soft_rst),
    .strap_latch(strap_latch), .ld_start(ld_start), .ready(ready), .rst_bit(rst_bit),
    .phy_pd(phy_pd), .txrx_en(txrx_en));

  task automatic chk(input string req, input int act, input int exp, input string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic got(input int ev, input string req);
    int e;
    if (exp_q.size() == 0) chk(req, ev, 0, "unexpected event");
    else begin
      e = exp_q.pop_front();
      chk(req, ev, e, "event order");
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (sys_rst_n) begin
      cyc++;
      if (strap_latch) begin got(EV_STRAP, "R3"); strap_cyc = cyc; end
      if (ld_start) begin
        got(EV_LD, "R4");
        chk("R4", cyc - strap_cyc, WAKE_CYC, "strap to load start cycles");
      end
      if (ready && !prev_ready) got(EV_READY, "R5");
      if (soft_rst && !prev_soft) begin got(EV_SOFT, "R6"); busy_len = 0; end
      if (soft_rst) busy_len++;
      if (!soft_rst && prev_soft && !mac_rst) chk("R6", busy_len, SW_CYC, "soft reset length");
      prev_ready = ready;
      prev_soft  = soft_rst;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    sys_rst_n = 1'b0; pin_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ld_done = 1'b0;
    tick(3);
    chk("R11", mac_rst, 1, "mac_rst in reset");
    chk("R11", phy_rst, 1, "phy_rst in reset");
    chk("R11", ready, 0, "ready in reset");
    chk("R11", phy_pd, 0, "phy_pd in reset");
    sys_rst_n = 1'b1;
    tick(20);
    chk("R2", mac_rst, 1, "held during long low");
    chk("R11", ready, 0, "not ready before sequence");
    exp_q.push_back(EV_STRAP); exp_q.push_back(EV_LD);
    pin_n = 1'b1;
    tick(3);
    chk("R3", mac_rst, 0, "reset released after strap");
    tick(10);
    chk("R4", ready, 0, "not ready while loading");
    exp_q.push_back(EV_READY);
    ld_done = 1'b1; tick(1); ld_done = 1'b0;
    chk("R5", ready, 1, "ready after load done");
    chk("R8", txrx_en, 1, "paths enabled");

    pin_n = 1'b0; tick(5); pin_n = 1'b1; tick(6);
    chk("R1", mac_rst, 0, "glitch ignored mac");
    chk("R1", ready, 1, "glitch ignored ready");
    ld_done = 1'b1; tick(1); ld_done = 1'b0; tick(2);
    chk("R5", ready, 1, "stray done ignored");

    wr(2'd1, 16'h0001);
    chk("R8", phy_pd, 1, "gp bit0 powers down");
    chk("R8", txrx_en, 0, "paths gated");
    wr(2'd1, 16'h0000);
    chk("R8", phy_pd, 0, "gp bit cleared");
    wr(2'd2, 16'h0800);
    chk("R8", phy_pd, 1, "phyctl bit11 powers down");
    wr(2'd2, 16'h0001);
    chk("R8", phy_pd, 0, "phyctl bit0 not power-down");
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'h0800);

    exp_q.push_back(EV_SOFT); exp_q.push_back(EV_READY);
    wr(2'd0, 16'h0001);
    chk("R6", soft_rst, 1, "soft reset active");
    chk("R6", rst_bit, 1, "reset bit reads 1");
    chk("R6", ready, 0, "not ready in soft reset");
    chk("R6", mac_rst, 0, "no full reset");
    wr(2'd2, 16'h0000);
    tick(25);
    chk("R6", ready, 1, "ready after soft reset");
    chk("R6", rst_bit, 0, "reset bit self-clears");
    chk("R9", phy_pd, 1, "write during soft reset ignored");
    wr(2'd2, 16'h0000);
    chk("R7", phy_pd, 0, "gp bit cleared by soft reset");
    wr(2'd0, 16'hFFFE);
    chk("R6", soft_rst, 0, "bit0 clear no reset");

    wr(2'd1, 16'h0001);
    exp_q.push_back(EV_SOFT);
    wr(2'd0, 16'h0001);
    tick(2);
    pin_n = 1'b0;
    exp_q.push_back(EV_STRAP); exp_q.push_back(EV_LD);
    tick(14);
    chk("R10", mac_rst, 1, "soft reset aborted by pin");
    chk("R10", soft_rst, 0, "soft reset dropped");
    chk("R2", phy_pd, 0, "power-down cleared");
    wr(2'd1, 16'h0001);
    chk("R9", phy_pd, 0, "write in hold ignored");
    pin_n = 1'b1;
    tick(10);
    chk("R10", ready, 0, "in load phase");
    pin_n = 1'b0;
    tick(14);
    chk("R10", mac_rst, 1, "load aborted by pin");
    exp_q.push_back(EV_STRAP); exp_q.push_back(EV_LD);
    pin_n = 1'b1;
    tick(12);
    exp_q.push_back(EV_READY);
    ld_done = 1'b1; tick(1); ld_done = 1'b0;
    chk("R10", ready, 1, "ready after restarted sequence");
    tick(2);
    chk("R3", exp_q.size(), 0, "all expected events seen");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule